// File: doc/BRIEF.md
# Cartridge wait-state timing controller

This block turns a 16-bit wait-control word into per-region access latencies and stalls bus requests for as long as those latencies call for. The control word sets the first-access and sequential waits of three external ROM windows and the wait of one save-memory window. One bit of the word removes the prefetch-path latency of the ROM windows.

Each request names a region, an access width (16 or 32 bits), an access kind (non-sequential, sequential or prefetch path), a load or store direction and a number of extra beats. An idle controller accepts a request in the cycle that the request is valid. It then holds `wait_o` high for the computed number of cycles and marks the end with a one-cycle `done_o`.

The block also reports, without a clock edge, the total cost of a 32-bit burst to the requested region. A bus master can use that figure to schedule transfers ahead of time.

Top module: `ws_timing_ctrl`

## Requirements
- R1: After reset the wait-control word is 0, `wait_o` and `done_o` are low, and all latencies equal those decoded from a word of 0.
- R2: Region codes are as follows. Codes 8 and 9 are ROM window 0, codes 10 and 11 are window 1, and codes 12 and 13 are window 2. Code 14 is the save window. For every ROM window and for the save window, a 2-bit first-wait index of 0, 1, 2 or 3 gives a 16-bit first wait of 4, 3, 2 or 8 cycles.
- R3: Field positions are as follows. The save index is bits [1:0]. Window 0 takes its index from [3:2] and its sequential bit from 4. Window 1 uses [6:5] and bit 7. Window 2 uses [9:8] and bit 10. A sequential bit of 1 gives a 16-bit sequential wait of 1. A sequential bit of 0 gives 2, 4 or 8 for windows 0, 1 and 2.
- R4: For a ROM window, the 32-bit non-sequential wait is the 16-bit first wait plus the 16-bit sequential wait plus 1. The 32-bit sequential wait is twice the 16-bit sequential wait plus 1. For the save window, all 16-bit waits equal the selected value v, and all 32-bit waits equal 2v+1.
- R5: When bit 14 is set, the prefetch-path wait of the three ROM windows is 0 at both widths. When bit 14 is clear, it equals the sequential wait of the same width. For all other regions, including the save window, the prefetch-path wait always equals the sequential wait.
- R6: Region 2 has a wait of 2 at 16 bits and 5 at 32 bits for every access kind. All regions other than 2 and 8 to 14 have a wait of 0. The control word has no effect on any of these regions.
- R7: The access-kind code is 0 for non-sequential, 1 for sequential and 2 for prefetch path. Code 3 acts as non-sequential. A request with E extra beats stalls for base + w + E×(1+s) cycles. Here base is 2 for a load and 1 for a store, w is the wait of the chosen kind and width, and s is the sequential wait of that width.
- R8: `wait_o` is high for exactly the stall count of cycles, starting the cycle after the accepting edge. `done_o` is high for one cycle, in the cycle that `wait_o` falls.
- R9: A request presented while `wait_o` is high is ignored. It neither changes the stall in progress nor starts a new one.
- R10: A write to the control word applies to requests accepted from the next cycle onward. A request accepted in the same cycle as the write uses the old word. A stall in progress keeps the length it was given when accepted.
- R11: `burst_cost_o` equals (1 + 32-bit non-sequential wait) + E×(1 + 32-bit sequential wait) for the requested region and extra-beat count E, combinationally from the inputs and the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the wait-control word |
| cfg_data_i | input | 16 | New wait-control word |
| req_valid_i | input | 1 | Request present |
| req_region_i | input | 4 | Region code of the request |
| req_wide_i | input | 1 | 1 for a 32-bit access, 0 for 16-bit |
| req_mode_i | input | 2 | Access kind: 0 non-sequential, 1 sequential, 2 prefetch path, 3 as 0 |
| req_store_i | input | 1 | 1 for a store, 0 for a load |
| req_extra_i | input | EXTRA_W | Extra beats after the first access |
| wait_o | output | 1 | Stall in progress |
| done_o | output | 1 | One-cycle end-of-stall pulse |
| burst_cost_o | output | COST_W | Cycle cost of a 32-bit burst to the requested region |

## Verification
A wrong entry in the decoded latency table appears on `burst_cost_o` in the same cycle that a request to that region is presented, before any clock edge. For the prefetch, 16-bit and load/store variants, a wrong entry appears only as a `wait_o` pulse that is too long or too short, visible when `done_o` arrives. A counter that loads late, drops a count or ignores the busy state shows up within the first stall as a wrong `wait_o` length, a `done_o` not aligned with the falling edge of `wait_o`, or a second stall that nobody requested. Control writes made during a stall and in the accepting cycle are checked by the length of that stall and of the next one.

// File: rtl/ws_timing_pkg.sv
package ws_timing_pkg;
  localparam int CFG_W    = 16;
  localparam int LAT_W    = 5;
  localparam int NREG     = 16;
  localparam int REG_W    = $clog2(NREG);
  localparam int NWIN     = 3;
  localparam int WIN_BASE = 8;
  localparam int SRAM_REG = 14;
  localparam int WRAM_REG = 2;
  localparam int PF_BIT   = 14;

  typedef enum logic [1:0] {
    ACC_NSEQ = 2'd0,
    ACC_SEQ  = 2'd1,
    ACC_PF   = 2'd2,
    ACC_ALT  = 2'd3
  } acc_e;

  // n = first access, s = sequential, p = prefetch path
  typedef struct packed {
    logic [LAT_W-1:0] n16;
    logic [LAT_W-1:0] s16;
    logic [LAT_W-1:0] p16;
    logic [LAT_W-1:0] n32;
    logic [LAT_W-1:0] s32;
    logic [LAT_W-1:0] p32;
  } lat_t;

  localparam lat_t WRAM_LAT = '{n16: 5'd2, s16: 5'd2, p16: 5'd2,
                                n32: 5'd5, s32: 5'd5, p32: 5'd5};

  function automatic logic [LAT_W-1:0] first_wait(input logic [1:0] idx);
    case (idx)
      2'd0:    return LAT_W'(4);
      2'd1:    return LAT_W'(3);
      2'd2:    return LAT_W'(2);
      default: return LAT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/ws_cfg_decode.sv
module ws_cfg_decode
  import ws_timing_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  output lat_t             lat_o [NREG]
);
  logic [CFG_W-1:0] cfg_q;
  logic             pf_en;
  lat_t             win_lat [NWIN];
  lat_t             sram_lat;
  logic [LAT_W-1:0] sram_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_data_i;
  end

  assign pf_en = cfg_q[PF_BIT];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam int FLO  = 2 + 3 * w;
    localparam int SBIT = FLO + 2;
    localparam logic [LAT_W-1:0] SLOW = LAT_W'(2 << w);
    logic [LAT_W-1:0] n16, s16, n32, s32;
    assign n16 = first_wait(cfg_q[FLO +: 2]);
    assign s16 = cfg_q[SBIT] ? LAT_W'(1) : SLOW;
    assign n32 = n16 + s16 + LAT_W'(1);
    assign s32 = (s16 << 1) + LAT_W'(1);
    assign win_lat[w] = '{n16: n16, s16: s16, p16: pf_en ? '0 : s16,
                          n32: n32, s32: s32, p32: pf_en ? '0 : s32};
  end

  assign sram_v   = first_wait(cfg_q[1:0]);
  assign sram_lat = '{n16: sram_v, s16: sram_v, p16: sram_v,
                      n32: (sram_v << 1) + LAT_W'(1),
                      s32: (sram_v << 1) + LAT_W'(1),
                      p32: (sram_v << 1) + LAT_W'(1)};

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      lat_o[r] = '0;
      if (r == WRAM_REG)
        lat_o[r] = WRAM_LAT;
      else if (r >= WIN_BASE && r < WIN_BASE + 2 * NWIN)
        lat_o[r] = win_lat[(r - WIN_BASE) / 2];
      else if (r == SRAM_REG)
        lat_o[r] = sram_lat;
    end
  end
endmodule

// File: rtl/ws_cost_calc.sv
module ws_cost_calc
  import ws_timing_pkg::*;
#(
  parameter int EXTRA_W = 5,
  parameter int COST_W  = 12
) (
  input  lat_t               lat_i [NREG],
  input  logic [REG_W-1:0]   region_i,
  input  logic               wide_i,
  input  acc_e               mode_i,
  input  logic               store_i,
  input  logic [EXTRA_W-1:0] extra_i,
  output logic [COST_W-1:0]  stall_o,
  output logic [COST_W-1:0]  burst_o
);
  lat_t             sel;
  logic [LAT_W-1:0] first_w, seq_w;
  logic [COST_W-1:0] base;

  always_comb begin
    sel = lat_i[region_i];
    unique case (mode_i)
      ACC_SEQ: first_w = wide_i ? sel.s32 : sel.s16;
      ACC_PF:  first_w = wide_i ? sel.p32 : sel.p16;
      default: first_w = wide_i ? sel.n32 : sel.n16;
    endcase
    seq_w = wide_i ? sel.s32 : sel.s16;
    base  = store_i ? COST_W'(1) : COST_W'(2);
    stall_o = base + COST_W'(first_w)
            + COST_W'(extra_i) * (COST_W'(seq_w) + COST_W'(1));
    burst_o = COST_W'(1) + COST_W'(sel.n32)
            + COST_W'(extra_i) * (COST_W'(sel.s32) + COST_W'(1));
  end
endmodule

// File: rtl/ws_stall_ctr.sv
module ws_stall_ctr #(
  parameter int COST_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [COST_W-1:0] total_i,
  output logic              wait_o,
  output logic              done_o
);
  logic [COST_W-1:0] cnt_q;
  logic              busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q <= COST_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - COST_W'(1);
        end
      end else if (req_valid_i) begin
        busy_q <= 1'b1;
        cnt_q  <= total_i;
      end
    end
  end

  assign wait_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/ws_timing_ctrl.sv
module ws_timing_ctrl
  import ws_timing_pkg::*;
#(
  parameter  int EXTRA_W = 5,
  localparam int COST_W  = EXTRA_W + 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [15:0]        cfg_data_i,
  input  logic               req_valid_i,
  input  logic [3:0]         req_region_i,
  input  logic               req_wide_i,
  input  logic [1:0]         req_mode_i,
  input  logic               req_store_i,
  input  logic [EXTRA_W-1:0] req_extra_i,
  output logic               wait_o,
  output logic               done_o,
  output logic [COST_W-1:0]  burst_cost_o
);
  lat_t              lat_tab [NREG];
  logic [COST_W-1:0] stall_cnt;

  ws_cfg_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_data_i (cfg_data_i),
    .lat_o      (lat_tab)
  );

  ws_cost_calc #(.EXTRA_W(EXTRA_W), .COST_W(COST_W)) u_cost (
    .lat_i    (lat_tab),
    .region_i (req_region_i),
    .wide_i   (req_wide_i),
    .mode_i   (acc_e'(req_mode_i)),
    .store_i  (req_store_i),
    .extra_i  (req_extra_i),
    .stall_o  (stall_cnt),
    .burst_o  (burst_cost_o)
  );

  ws_stall_ctr #(.COST_W(COST_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .total_i     (stall_cnt),
    .wait_o      (wait_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/ws_timing_chk.sv
module ws_timing_chk #(
  parameter int EXTRA_W = 5,
  parameter int COST_W  = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [3:0]         req_region_i,
  input logic [EXTRA_W-1:0] req_extra_i,
  input logic               wait_o,
  input logic               done_o,
  input logic [COST_W-1:0]  burst_cost_o
);
  AST_ACCEPT_STARTS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !wait_o) |=> wait_o); // R8

  AST_REQ_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && req_valid_i && !done_o) |=> (wait_o || done_o)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_FALL_GIVES_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wait_o) |-> done_o); // R8

  AST_DONE_AFTER_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!wait_o && $past(wait_o))); // R8

  AST_ZERO_REGION_COST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_region_i == 4'd3 && req_extra_i == '0) |-> (burst_cost_o == COST_W'(1))); // R6
endmodule

bind ws_timing_ctrl ws_timing_chk #(.EXTRA_W(EXTRA_W), .COST_W(COST_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_region_i (req_region_i),
  .req_extra_i  (req_extra_i),
  .wait_o       (wait_o),
  .done_o       (done_o),
  .burst_cost_o (burst_cost_o)
);

// File: tb/ws_timing_ctrl_test.sv
module ws_timing_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int EXTRA_W    = 5;
  localparam int COST_W     = EXTRA_W + 7;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [15:0] cfg;
    logic [3:0]  region;
    logic        wide;
    logic [1:0]  mode;
    logic        store;
    logic [4:0]  extra;
    logic [11:0] exp_t;
    logic [11:0] exp_cost;
    logic [3:0]  rq;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0000, 4'd8,  1'b0, 2'd0, 1'b0, 5'd0, 12'd6,  12'd8,  4'd2},  // R2 w0 default
    '{16'h0000, 4'd9,  1'b1, 2'd1, 1'b0, 5'd0, 12'd7,  12'd8,  4'd4},  // R4 s32=5
    '{16'h0000, 4'd12, 1'b1, 2'd0, 1'b1, 5'd2, 12'd50, 12'd50, 4'd7},  // R7 burst store
    '{16'h0014, 4'd8,  1'b0, 2'd0, 1'b0, 5'd0, 12'd5,  12'd6,  4'd3},  // R3 w0 fields
    '{16'h00C0, 4'd10, 1'b1, 2'd1, 1'b0, 5'd3, 12'd17, 12'd17, 4'd3},  // R3 w1 fields
    '{16'h0300, 4'd13, 1'b0, 2'd0, 1'b1, 5'd1, 12'd18, 12'd36, 4'd2},  // R2 idx3 w2
    '{16'h0003, 4'd14, 1'b1, 2'd1, 1'b0, 5'd0, 12'd19, 12'd18, 4'd4},  // R4 save 2v+1
    '{16'h0001, 4'd14, 1'b0, 2'd0, 1'b1, 5'd0, 12'd4,  12'd8,  4'd2},  // R2 save idx1
    '{16'h4000, 4'd8,  1'b1, 2'd2, 1'b0, 5'd0, 12'd2,  12'd8,  4'd5},  // R5 prefetch on
    '{16'h0000, 4'd8,  1'b1, 2'd2, 1'b0, 5'd0, 12'd7,  12'd8,  4'd5},  // R5 prefetch off
    '{16'h4000, 4'd10, 1'b0, 2'd2, 1'b1, 5'd2, 12'd11, 12'd30, 4'd5},  // R5 with beats
    '{16'h47FF, 4'd2,  1'b1, 2'd0, 1'b0, 5'd1, 12'd13, 12'd12, 4'd6},  // R6 work RAM
    '{16'h47FF, 4'd3,  1'b0, 2'd0, 1'b1, 5'd0, 12'd1,  12'd1,  4'd6},  // R6 zero region
    '{16'h47FF, 4'd0,  1'b1, 2'd1, 1'b0, 5'd0, 12'd2,  12'd1,  4'd6},  // R6 region 0
    '{16'h47FF, 4'd15, 1'b0, 2'd3, 1'b1, 5'd0, 12'd1,  12'd1,  4'd6},  // R6 region 15
    '{16'h4002, 4'd14, 1'b0, 2'd2, 1'b0, 5'd0, 12'd4,  12'd6,  4'd5},  // R5 save untouched
    '{16'h0000, 4'd12, 1'b0, 2'd3, 1'b0, 5'd0, 12'd6,  12'd14, 4'd7}   // R7 code 3
  };

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               cfg_we_i = 1'b0;
  logic [15:0]        cfg_data_i = '0;
  logic               req_valid_i = 1'b0;
  logic [3:0]         req_region_i = '0;
  logic               req_wide_i = 1'b0;
  logic [1:0]         req_mode_i = '0;
  logic               req_store_i = 1'b0;
  logic [EXTRA_W-1:0] req_extra_i = '0;
  logic               wait_o, done_o;
  logic [COST_W-1:0]  burst_cost_o;

  int checks = 0;
  int errors = 0;

  ws_timing_ctrl #(.EXTRA_W(EXTRA_W)) uut (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_data_i, .req_valid_i, .req_region_i,
    .req_wide_i, .req_mode_i, .req_store_i, .req_extra_i,
    .wait_o, .done_o, .burst_cost_o
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input int v);
    @(negedge clk_i);
    cfg_we_i = 1'b1;
    cfg_data_i = 16'(v);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // poke: 0 none, 1 control write mid-stall, 2 extra request mid-stall
  task automatic run(input bit cfg_en, input int cfg_v, input int region, input bit wide,
                     input int mode, input bit store, input int extra, input int exp_t,
                     input int exp_cost, input int poke, input int poke_cfg, input string tag);
    int n;
    @(negedge clk_i);
    req_valid_i  = 1'b1;
    req_region_i = 4'(region);
    req_wide_i   = wide;
    req_mode_i   = 2'(mode);
    req_store_i  = store;
    req_extra_i  = EXTRA_W'(extra);
    cfg_we_i     = cfg_en;
    cfg_data_i   = 16'(cfg_v);
    #1;
    if (exp_cost >= 0)
      chk(int'(burst_cost_o) == exp_cost, {tag, " burst cost"}, int'(burst_cost_o), exp_cost);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    cfg_we_i    = 1'b0;
    n = 0;
    while (wait_o && n < 5000) begin
      n++;
      cfg_we_i = 1'b0;
      if (poke == 1 && n == 2) begin
        cfg_we_i   = 1'b1;
        cfg_data_i = 16'(poke_cfg);
      end
      if (poke == 2) begin
        req_valid_i  = (n >= 2 && n <= 4);
        req_region_i = 4'd3;
        req_store_i  = 1'b1;
        req_extra_i  = '0;
      end
      @(negedge clk_i);
    end
    cfg_we_i    = 1'b0;
    req_valid_i = 1'b0;
    chk(n == exp_t, {tag, " stall length"}, n, exp_t);
    chk(done_o == 1'b1, {tag, " done at wait fall"}, int'(done_o), 1);
    @(negedge clk_i);
    chk(done_o == 1'b0 && wait_o == 1'b0, {tag, " done single, idle"},
        int'({done_o, wait_o}), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", WATCHDOG, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: idle outputs and default decode
    chk(wait_o == 1'b0, "R1 wait low", int'(wait_o), 0);
    chk(done_o == 1'b0, "R1 done low", int'(done_o), 0);
    req_region_i = 4'd8;
    req_extra_i  = '0;
    #1;
    chk(int'(burst_cost_o) == 8, "R1 default w0 cost", int'(burst_cost_o), 8);
    req_region_i = 4'd12;
    req_extra_i  = EXTRA_W'(1);
    #1;
    chk(int'(burst_cost_o) == 32, "R11 default w2 burst", int'(burst_cost_o), 32);
    run(1'b0, 0, 14, 1'b0, 0, 1'b0, 0, 6, 10, 0, 0, "R1 default save");

    for (int i = 0; i < NVEC; i++) begin
      wr_cfg(int'(VECS[i].cfg));
      run(1'b0, 0, int'(VECS[i].region), VECS[i].wide, int'(VECS[i].mode),
          VECS[i].store, int'(VECS[i].extra), int'(VECS[i].exp_t),
          int'(VECS[i].exp_cost), 0, 0, $sformatf("R%0d vec%0d", VECS[i].rq, i));
    end

    // R10: write during stall keeps length; next request sees new word
    wr_cfg(16'h0000);
    run(1'b0, 0, 8, 1'b0, 0, 1'b0, 0, 6, 8, 1, 16'h0008, "R10 in-flight keeps");
    run(1'b0, 0, 8, 1'b0, 0, 1'b0, 0, 4, 6, 0, 0, "R10 new word applied");
    run(1'b1, 16'h000C, 8, 1'b0, 0, 1'b0, 0, 4, -1, 0, 0, "R10 same-cycle old word");
    run(1'b0, 0, 8, 1'b0, 0, 1'b0, 0, 10, 12, 0, 0, "R10 next uses new");

    // R9: requests during a stall are dropped
    wr_cfg(16'h0000);
    run(1'b0, 0, 12, 1'b1, 0, 1'b1, 2, 50, 50, 2, 0, "R9 busy request ignored");
    repeat (3) begin
      @(negedge clk_i);
      chk(wait_o == 1'b0, "R9 no late stall", int'(wait_o), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule